// File: doc/BRIEF.md
# Phased Multicycle 16-bit Register Processor

This block is a small register-based processor core for a 16-bit instruction word. It holds a program counter, an instruction latch, a memory address latch and a memory data latch, plus eight general registers of 16 bits each. A control state machine carries every instruction through a fixed order of phases: fetch, decode, address evaluation, operand fetch, execute and result store. An instruction passes only through the phases it needs. All traffic to the word-addressed internal memory goes through the address and data latches, one step per clock.

The core runs register add, bitwise and, bitwise invert, a load from base register plus signed offset, and a store to base register plus signed offset. Every other opcode is a no-op. A preload port fills the memory while the core is held in reset or halted. Two observation ports read back any memory word and any register. A halt input freezes the clock enable, so that no state advances while it is high.

Top module: `phased_cpu`

## Requirements
- R1: While `rst_n` is low, `pc_out` reads 0, every register reads 0, and the controller waits in its first fetch phase.
- R2: Each instruction is read from the word that `pc_out` points to, and `pc_out` then advances by exactly one, wrapping at the memory size.
- R3: Opcode 4'b0001 in bits [15:12] adds the register selected by bits [8:6] to the register selected by bits [2:0]. The sum, modulo 2^16, goes to the register selected by bits [11:9]. The instruction takes 7 clocks.
- R4: Opcode 4'b0101 writes the bitwise AND of the same two source fields to the register selected by bits [11:9]. It takes 7 clocks.
- R5: Opcode 4'b1001 writes the bitwise inverse of the register selected by bits [8:6] to the register selected by bits [11:9]. It takes 7 clocks.
- R6: Opcode 4'b0110 sign-extends bits [5:0] and adds them to the base register in bits [8:6]. The low address bits of the result select a memory word, which is written to the register in bits [11:9]. Offsets from -32 to +31 are allowed. It takes 8 clocks.
- R7: Opcode 4'b0111 forms its address the same way as R6 and writes the register selected by bits [11:9] into that memory word. Only this opcode writes memory. It takes 8 clocks.
- R8: Any other opcode takes 4 clocks and changes no register and no memory word. Only the four register-writing opcodes write a register.
- R9: While `halt` is high, `pc_out`, the registers, the memory contents written by the core and the controller phase all stay unchanged. Execution resumes exactly where it stopped.
- R10: The opcode decoder raises exactly one of its 16 lines, the line whose index equals bits [15:12].
- R11: With `pre_we` high, `pre_data` is written to the word at `pre_addr` on the clock edge. `obs_mem_data` and `obs_reg_data` show the addressed word and register without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Freezes all core state while high |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | ADDR_W | Preload word address |
| pre_data | input | 16 | Preload word |
| obs_mem_addr | input | ADDR_W | Memory observation address |
| obs_mem_data | output | 16 | Memory word at `obs_mem_addr` |
| obs_reg_sel | input | 3 | Register observation select |
| obs_reg_data | output | 16 | Contents of the selected register |
| pc_out | output | ADDR_W | Program counter |

## Verification
The hardest cases to reach from the ports are a halt that lands partway through an instruction's phases and a store followed by a load from the same word through an address that wraps. A directed program sets up the wrap: a negative offset from a zero base reaches the top of memory, and a base of 0x8000 with offset -1 folds back onto that same word. It also holds halt for six clocks inside an instruction. A seeded random program then mixes all five operations with unsupported opcodes and a second mid-instruction halt. A bench-side instruction model predicts the program counter after every instruction and the final contents of registers and memory.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

    localparam int XLEN  = 16;
    localparam int OPC_W = 4;
    localparam int NLINE = 1 << OPC_W;
    localparam int NREG  = 8;
    localparam int SEL_W = $clog2(NREG);

    localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
    localparam logic [OPC_W-1:0] OPC_STR = 4'b0111;

    localparam logic [NLINE-1:0] SUPPORTED_MASK =
        (NLINE'(1) << OPC_ADD) | (NLINE'(1) << OPC_AND) | (NLINE'(1) << OPC_NOT) |
        (NLINE'(1) << OPC_LDR) | (NLINE'(1) << OPC_STR);

    typedef enum logic [3:0] {
        PH_FETCH_MAR,
        PH_FETCH_READ,
        PH_FETCH_IR,
        PH_DECODE,
        PH_EVAL_ADDR,
        PH_OPND_MAR,
        PH_OPND_READ,
        PH_OPND_REGS,
        PH_EXECUTE,
        PH_STORE_REG,
        PH_STORE_MDR,
        PH_STORE_MAR,
        PH_STORE_WRITE
    } phase_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ea;
        logic mdr_from_mem;
        logic mdr_from_reg;
        logic ir_load;
        logic pc_inc;
        logic ea_load;
        logic opnd_load;
        logic alu_load;
        logic rf_we;
        logic mem_we;
    } ctl_t;

    function automatic logic [XLEN-1:0] alu_eval(input logic [OPC_W-1:0] op,
                                                 input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b);
        logic [XLEN-1:0] r;
        case (op)
            OPC_AND: r = a & b;
            OPC_NOT: r = ~a;
            default: r = a + b;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cpu_decoder.sv
module cpu_decoder #(
    parameter int OPC_W = 4,
    localparam int NLINE = 1 << OPC_W
) (
    input  logic [OPC_W-1:0] opcode,
    output logic [NLINE-1:0] lines
);
    for (genvar i = 0; i < NLINE; i++) begin : g_line
        assign lines[i] = (opcode == OPC_W'(i));
    end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [SEL_W-1:0] ra1,
    output logic [DW-1:0]    rd1,
    input  logic [SEL_W-1:0] ra2,
    output logic [DW-1:0]    rd2,
    input  logic [SEL_W-1:0] ra3,
    output logic [DW-1:0]    rd3
);
    logic [DW-1:0] regs [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[r] <= '0;
            end else if (we && waddr == SEL_W'(r)) begin
                regs[r] <= wdata;
            end
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
    assign rd3 = regs[ra3];
endmodule

// File: rtl/cpu_memory.sv
module cpu_memory #(
    parameter int ADDR_W = 8,
    parameter int DW     = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DW-1:0]     pre_data,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [ADDR_W-1:0] obs_addr,
    output logic [DW-1:0]     obs_data
);
    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (pre_we) begin
            words[pre_addr] <= pre_data;
        end else if (we) begin
            words[addr] <= wdata;
        end
    end

    assign rdata    = words[addr];
    assign obs_data = words[obs_addr];
endmodule

// File: rtl/cpu_ctrl.sv
module cpu_ctrl
    import cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic [NLINE-1:0] op_lines,
    output phase_e           phase,
    output ctl_t             ctl
);
    phase_e state_q, state_d;
    logic   is_alu, is_mem, is_st, no_op;

    assign is_alu = op_lines[OPC_ADD] | op_lines[OPC_AND] | op_lines[OPC_NOT];
    assign is_mem = op_lines[OPC_LDR] | op_lines[OPC_STR];
    assign is_st  = op_lines[OPC_STR];
    assign no_op  = |(op_lines & ~SUPPORTED_MASK);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_FETCH_MAR;
        end else if (clk_en) begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_FETCH_MAR:   state_d = PH_FETCH_READ;
            PH_FETCH_READ:  state_d = PH_FETCH_IR;
            PH_FETCH_IR:    state_d = PH_DECODE;
            PH_DECODE: begin
                if (no_op)        state_d = PH_FETCH_MAR;
                else if (is_alu)  state_d = PH_OPND_REGS;
                else if (is_mem)  state_d = PH_EVAL_ADDR;
                else              state_d = PH_FETCH_MAR;
            end
            PH_EVAL_ADDR:   state_d = is_st ? PH_STORE_MDR : PH_OPND_MAR;
            PH_OPND_MAR:    state_d = PH_OPND_READ;
            PH_OPND_READ:   state_d = PH_STORE_REG;
            PH_OPND_REGS:   state_d = PH_EXECUTE;
            PH_EXECUTE:     state_d = PH_STORE_REG;
            PH_STORE_REG:   state_d = PH_FETCH_MAR;
            PH_STORE_MDR:   state_d = PH_STORE_MAR;
            PH_STORE_MAR:   state_d = PH_STORE_WRITE;
            PH_STORE_WRITE: state_d = PH_FETCH_MAR;
            default:        state_d = PH_FETCH_MAR;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state_q)
            PH_FETCH_MAR:   ctl.mar_from_pc  = 1'b1;
            PH_FETCH_READ:  ctl.mdr_from_mem = 1'b1;
            PH_FETCH_IR: begin
                ctl.ir_load = 1'b1;
                ctl.pc_inc  = 1'b1;
            end
            PH_DECODE:      ;
            PH_EVAL_ADDR:   ctl.ea_load      = 1'b1;
            PH_OPND_MAR:    ctl.mar_from_ea  = 1'b1;
            PH_OPND_READ:   ctl.mdr_from_mem = 1'b1;
            PH_OPND_REGS:   ctl.opnd_load    = 1'b1;
            PH_EXECUTE:     ctl.alu_load     = 1'b1;
            PH_STORE_REG:   ctl.rf_we        = 1'b1;
            PH_STORE_MDR:   ctl.mdr_from_reg = 1'b1;
            PH_STORE_MAR:   ctl.mar_from_ea  = 1'b1;
            PH_STORE_WRITE: ctl.mem_we       = 1'b1;
            default:        ;
        endcase
    end

    assign phase = state_q;
endmodule

// File: rtl/phased_cpu.sv
module phased_cpu
    import cpu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [XLEN-1:0]   pre_data,
    input  logic [ADDR_W-1:0] obs_mem_addr,
    output logic [XLEN-1:0]   obs_mem_data,
    input  logic [SEL_W-1:0]  obs_reg_sel,
    output logic [XLEN-1:0]   obs_reg_data,
    output logic [ADDR_W-1:0] pc_out
);
    localparam int OFF_W = 6;

    logic              clk_en;
    logic [ADDR_W-1:0] pc, mar, ea;
    logic [XLEN-1:0]   ir, mdr, opa, opb, alu_q;
    logic [XLEN-1:0]   rd1, rd2, mem_rdata, rf_wdata;
    logic [SEL_W-1:0]  ra2;
    logic [ADDR_W-1:0] offset;
    logic [NLINE-1:0]  op_lines;
    logic              rf_we, mem_we;
    phase_e            phase;
    ctl_t              ctl;

    assign clk_en = ~halt;
    assign offset = {{(ADDR_W-OFF_W){ir[OFF_W-1]}}, ir[OFF_W-1:0]};

    cpu_decoder #(.OPC_W(OPC_W)) u_dec (
        .opcode (ir[XLEN-1 -: OPC_W]),
        .lines  (op_lines)
    );

    cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .op_lines (op_lines),
        .phase    (phase),
        .ctl      (ctl)
    );

    assign ra2      = op_lines[OPC_STR] ? ir[11:9] : ir[2:0];
    assign rf_wdata = op_lines[OPC_LDR] ? mdr : alu_q;
    assign rf_we    = ctl.rf_we;
    assign mem_we   = ctl.mem_we;

    cpu_regfile #(.NREG(NREG), .DW(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we & clk_en),
        .waddr (ir[11:9]),
        .wdata (rf_wdata),
        .ra1   (ir[8:6]),
        .rd1   (rd1),
        .ra2   (ra2),
        .rd2   (rd2),
        .ra3   (obs_reg_sel),
        .rd3   (obs_reg_data)
    );

    cpu_memory #(.ADDR_W(ADDR_W), .DW(XLEN)) u_mem (
        .clk      (clk),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .we       (mem_we & clk_en),
        .addr     (mar),
        .wdata    (mdr),
        .rdata    (mem_rdata),
        .obs_addr (obs_mem_addr),
        .obs_data (obs_mem_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            mar   <= '0;
            ea    <= '0;
            ir    <= '0;
            mdr   <= '0;
            opa   <= '0;
            opb   <= '0;
            alu_q <= '0;
        end else if (clk_en) begin
            if (ctl.mar_from_pc)  mar   <= pc;
            if (ctl.mar_from_ea)  mar   <= ea;
            if (ctl.mdr_from_mem) mdr   <= mem_rdata;
            if (ctl.mdr_from_reg) mdr   <= rd2;
            if (ctl.ir_load)      ir    <= mdr;
            if (ctl.pc_inc)       pc    <= pc + ADDR_W'(1);
            if (ctl.ea_load)      ea    <= rd1[ADDR_W-1:0] + offset;
            if (ctl.opnd_load) begin
                opa <= rd1;
                opb <= rd2;
            end
            if (ctl.alu_load)     alu_q <= alu_eval(ir[XLEN-1 -: OPC_W], opa, opb);
        end
    end

    assign pc_out = pc;
endmodule

// File: rtl/cpu_checker.sv
module cpu_checker
    import cpu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              halt,
    input logic [ADDR_W-1:0] pc_out,
    input phase_e            phase,
    input logic [NLINE-1:0]  op_lines,
    input logic              rf_we,
    input logic              mem_we
);
    AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> pc_out == '0); // R1
    AST_RESET_PHASE: assert property (@(posedge clk) !rst_n |=> phase == PH_FETCH_MAR); // R1
    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_out != $past(pc_out)) |-> (pc_out == $past(pc_out) + ADDR_W'(1))); // R2
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> ($stable(pc_out) && $stable(phase))); // R9
    AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(op_lines) == 1); // R10
    AST_MEM_WRITE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> op_lines[OPC_STR]); // R7
    AST_RF_WRITE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (op_lines[OPC_ADD] | op_lines[OPC_AND] | op_lines[OPC_NOT] | op_lines[OPC_LDR])); // R8
endmodule

bind phased_cpu cpu_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .pc_out   (pc_out),
    .phase    (phase),
    .op_lines (op_lines),
    .rf_we    (rf_we),
    .mem_we   (mem_we)
);

// File: tb/phased_cpu_bench.sv
module phased_cpu_bench;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          halt = 1'b0;
    logic          pre_we = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic [15:0]   pre_data = '0;
    logic [AW-1:0] obs_mem_addr = '0;
    logic [15:0]   obs_mem_data;
    logic [2:0]    obs_reg_sel = '0;
    logic [15:0]   obs_reg_data;
    logic [AW-1:0] pc_out;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] image [DEPTH];
    logic [15:0] mmem  [DEPTH];
    logic [15:0] mreg  [8];
    logic [AW-1:0] mpc;

    always #4 clk = ~clk;

    phased_cpu #(.ADDR_W(AW)) u_phased_cpu (
        .clk(clk), .rst_n(rst_n), .halt(halt),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .obs_mem_addr(obs_mem_addr), .obs_mem_data(obs_mem_data),
        .obs_reg_sel(obs_reg_sel), .obs_reg_data(obs_reg_data),
        .pc_out(pc_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rrr(input logic [3:0] op, input int d, input int a, input int b);
        return {op, 3'(d), 3'(a), 3'b000, 3'(b)};
    endfunction

    function automatic logic [15:0] mop(input logic [3:0] op, input int d, input int b, input logic [5:0] off);
        return {op, 3'(d), 3'(b), off};
    endfunction

    function automatic int cycles_of(input logic [3:0] op);
        if (op == 4'b0001 || op == 4'b0101 || op == 4'b1001) return 7;
        if (op == 4'b0110 || op == 4'b0111) return 8;
        return 4;
    endfunction

    function automatic logic [AW-1:0] eaddr(input logic [15:0] ins);
        logic [15:0] s;
        s = mreg[ins[8:6]] + {{10{ins[5]}}, ins[5:0]};
        return s[AW-1:0];
    endfunction

    // Instruction-level model of R2..R8
    function automatic void model_step(input logic [15:0] ins);
        case (ins[15:12])
            4'b0001: mreg[ins[11:9]] = mreg[ins[8:6]] + mreg[ins[2:0]];
            4'b0101: mreg[ins[11:9]] = mreg[ins[8:6]] & mreg[ins[2:0]];
            4'b1001: mreg[ins[11:9]] = ~mreg[ins[8:6]];
            4'b0110: mreg[ins[11:9]] = mmem[eaddr(ins)];
            4'b0111: mmem[eaddr(ins)] = mreg[ins[11:9]];
            default: ;
        endcase
    endfunction

    function automatic logic [15:0] gen_rand();
        logic [3:0] op;
        case ($urandom % 6)
            0: return rrr(4'b0001, $urandom % 8, $urandom % 8, $urandom % 8);
            1: return rrr(4'b0101, $urandom % 8, $urandom % 8, $urandom % 8);
            2: return {4'b1001, 3'($urandom % 8), 3'($urandom % 8), 6'b111111};
            3: return mop(4'b0110, $urandom % 8, $urandom % 8, 6'($urandom));
            4: return mop(4'b0111, $urandom % 8, 0, {1'b1, 5'($urandom)});
            default: begin
                do op = 4'($urandom);
                while (op == 4'b0001 || op == 4'b0101 || op == 4'b1001 ||
                       op == 4'b0110 || op == 4'b0111);
                return {op, 12'($urandom)};
            end
        endcase
    endfunction

    task automatic enter_reset_and_load();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            pre_we   = 1'b1;
            pre_addr = AW'(i);
            pre_data = image[i];
            mmem[i]  = image[i];
            @(negedge clk);
        end
        pre_we = 1'b0;
        for (int r = 0; r < 8; r++) mreg[r] = '0;
        mpc = '0;
        chk("R1 pc in reset", 16'(pc_out), 16'h0);
        for (int r = 0; r < 8; r++) begin
            obs_reg_sel = 3'(r);
            #1;
            chk("R1 register in reset", obs_reg_data, 16'h0);
        end
        obs_mem_addr = AW'(DEPTH - 1);
        #1;
        chk("R11 preload readback", obs_mem_data, image[DEPTH-1]);
    endtask

    task automatic run_prog(input int n, input int halt_at);
        logic [15:0]   ins;
        logic [AW-1:0] held;
        rst_n = 1'b1;
        for (int i = 0; i < n; i++) begin
            ins = mmem[mpc];
            mpc = mpc + AW'(1);
            model_step(ins);
            if (i == halt_at) begin
                repeat (cycles_of(ins[15:12]) - 2) @(negedge clk);
                held = pc_out;
                halt = 1'b1;
                repeat (6) @(negedge clk);
                chk("R9 pc frozen under halt", 16'(pc_out), 16'(held));
                halt = 1'b0;
                repeat (2) @(negedge clk);
            end else begin
                repeat (cycles_of(ins[15:12])) @(negedge clk);
            end
            chk("R2 pc after instruction", 16'(pc_out), 16'(mpc));
        end
        halt = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 8; r++) begin
            obs_reg_sel = 3'(r);
            #1;
            chk("R3 R4 R5 R6 R8 register result", obs_reg_data, mreg[r]);
        end
        for (int a = 0; a < DEPTH; a++) begin
            obs_mem_addr = AW'(a);
            #1;
            chk("R7 R8 memory word", obs_mem_data, mmem[a]);
        end
        halt = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2024));
        // Directed program: offset extremes, wrap-around add, no-ops, store then load of one word
        for (int i = 0; i < DEPTH; i++) image[i] = '0;
        image[240] = 16'h7FFF;
        image[241] = 16'h8001;
        image[224] = 16'hBEEF;
        image[31]  = 16'h1234;
        image[0]  = mop(4'b0110, 1, 0, 6'b110000);   // R6 R1 = [240]
        image[1]  = mop(4'b0110, 2, 0, 6'b110001);   // R6 R2 = [241]
        image[2]  = rrr(4'b0001, 3, 1, 2);           // R3 wraps to 0
        image[3]  = rrr(4'b0101, 4, 1, 2);           // R4
        image[4]  = {4'b1001, 3'd5, 3'd1, 6'b111111}; // R5
        image[5]  = 16'h0000;                         // R8 no-op
        image[6]  = mop(4'b0111, 5, 0, 6'b111111);   // R7 [255] = R5
        image[7]  = mop(4'b0110, 6, 0, 6'b011111);   // R6 offset +31
        image[8]  = mop(4'b0110, 7, 0, 6'b100000);   // R6 offset -32
        image[9]  = 16'hF123;                         // R8 no-op
        image[10] = rrr(4'b0001, 1, 1, 1);           // R3
        image[11] = mop(4'b0110, 0, 5, 6'b111111);   // R6 wrap from 0x8000
        image[31] = 16'h1234;
        enter_reset_and_load();
        run_prog(12, 4);

        // Seeded random program
        for (int i = 0; i < DEPTH; i++) image[i] = 16'($urandom);
        for (int i = 0; i < 40; i++) image[i] = gen_rand();
        enter_reset_and_load();
        run_prog(40, 17);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule